// File: doc/BRIEF.md
# Interrupt Source Configuration Register File

This block holds the per-source configuration and pending state of an external interrupt controller that serves 31 sources, indexed 1 to 31. Each source has a 4-bit priority, an enable bit, a 2-bit trigger control and a pending latch fed by its own gateway. One further bit holds a global setting that a downstream arbiter uses to choose its priority order. Software reaches all of this through a plain register port. A write takes one cycle. A read returns its data one clock after the request.

Each gateway turns a raw request line into a pending bit. Bit 1 of the trigger control selects the mode: 1 is edge, 0 is level. Bit 0 inverts the polarity of the request. In edge mode a rising edge of the polarity-adjusted request sets the latch, and the latch stays set until software writes to the source's clear address. In level mode the latch follows the adjusted request. The enable, pending and priority vectors leave the block in parallel and go to an arbiter, which is not part of this block.

The map is word-aligned and sparse. Each region lives in its own 4 KiB page, and the source index sits in address bits [6:2]. All read data comes from registers, and all state is cleared by a synchronous active-high reset.

Top module: `irq_cfg_regfile`

## Requirements
- R1: After reset, every priority, enable, trigger control and pending latch is 0, the global bit is 0, and rd_data is 0.
- R2: The priority of source s (1..31) is at offset 4*s. It keeps bits [3:0] of the written data and reads back as exactly that value, zero-extended.
- R3: The enable of source s is at offset 0x2000+4*s. It keeps bit 0 of the written data and reads back as that bit.
- R4: The trigger control of source s is at offset 0x4000+4*s. It keeps bits [1:0] of the written data and reads back as those bits.
- R5: The global bit is at offset 0x3000. It keeps bit 0 of the written data, reads back as that bit, and drives order_cfg.
- R6: Offset 0x1000 returns the pending vector, with source s in bit s and bit 0 always 0. Writes to this offset change nothing.
- R7: With trigger control 2'b10 (edge, active high), a request going from 0 to 1 sets the source's pending latch at that clock edge. The latch stays set after the request returns to 0.
- R8: A write of any data to offset 0x5000+4*s clears the pending latch of source s in edge mode. If a new edge arrives in the same cycle, the edge wins.
- R9: With trigger control 2'b00 the pending bit equals the request, and with 2'b01 it equals the inverted request, one clock after the request is sampled. Clear writes have no effect in level mode.
- R10: Any other address reads 0 and ignores writes. This covers index 0, indexes 32 and up, misaligned addresses and unused pages.
- R11: If rd_en is high at a rising edge, rd_data holds the addressed value from that edge until the next one. If rd_en is low, rd_data is 0.
- R12: src_prio[4*s+3:4*s] and src_en[s] always equal the stored priority and enable of source s. Slice 0 and bit 0 are always 0.
- R13: In edge mode a transition of the request away from the active level never sets the latch. With trigger control 2'b11, a 1-to-0 request transition sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_en | input | 1 | Read request, sampled at the rising edge |
| rd_addr | input | 16 | Read byte offset |
| rd_data | output | 32 | Registered read data |
| wr_en | input | 1 | Write request |
| wr_addr | input | 16 | Write byte offset |
| wr_data | input | 32 | Write data |
| irq_req | input | 32 | Raw request per source (bit 0 unused) |
| src_en | output | 32 | Enable vector |
| src_pend | output | 32 | Pending vector |
| src_prio | output | 128 | Priorities, 4 bits per source |
| order_cfg | output | 1 | Global configuration bit |

## Verification
A wrong trigger control or a stuck gateway latch shows up on src_pend at the first clock edge after the request changes, and it shows up in the 0x1000 readback one cycle later. A corrupted priority or enable shows up on the parallel vectors in the cycle after the write. A decode that aliases one address onto another shows up only when a neighbouring field is read back. For that reason the bench rereads the whole map after every sweep of writes, including the writes to unmapped addresses.

// File: rtl/irq_cfg_pkg.sv
package irq_cfg_pkg;
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PRIO,
    SEL_PEND,
    SEL_EN,
    SEL_GLB,
    SEL_GWC,
    SEL_GWCLR
  } reg_sel_e;

  localparam int PAGE_LSB = 12;
endpackage

// File: rtl/irq_cfg_decode.sv
module irq_cfg_decode
  import irq_cfg_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int NUM_SRC = 32,
  parameter int IDX_W   = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic [IDX_W-1:0]  idx
);
  localparam int PAGE_W = ADDR_W - PAGE_LSB;

  logic [PAGE_W-1:0]   page;
  logic [PAGE_LSB-1:0] offs;
  logic                src_ok;
  logic                word0;

  always_comb begin
    page   = addr[ADDR_W-1:PAGE_LSB];
    offs   = addr[PAGE_LSB-1:0];
    idx    = offs[IDX_W+1:2];
    word0  = (offs == '0);
    src_ok = (offs[1:0] == 2'b00) && ((offs >> (IDX_W + 2)) == '0) &&
             (idx != '0) && (32'(idx) < NUM_SRC);
    case (page)
      PAGE_W'(0): sel = src_ok ? SEL_PRIO  : SEL_NONE;
      PAGE_W'(1): sel = word0  ? SEL_PEND  : SEL_NONE;
      PAGE_W'(2): sel = src_ok ? SEL_EN    : SEL_NONE;
      PAGE_W'(3): sel = word0  ? SEL_GLB   : SEL_NONE;
      PAGE_W'(4): sel = src_ok ? SEL_GWC   : SEL_NONE;
      PAGE_W'(5): sel = src_ok ? SEL_GWCLR : SEL_NONE;
      default:    sel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/irq_gateway.sv
module irq_gateway (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_i,
  input  logic [1:0] cfg_i,
  input  logic       clr_i,
  output logic       pend_o
);
  logic adj;
  logic prev_q;

  assign adj = req_i ^ cfg_i[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      prev_q <= adj;
      if (!cfg_i[1])
        pend_o <= adj;
      else if (adj && !prev_q)
        pend_o <= 1'b1;
      else if (clr_i)
        pend_o <= 1'b0;
    end
  end

  // R7
  edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_o && cfg_i[1] && !clr_i) |=> pend_o);

  // R8
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i && cfg_i[1] && !(req_i ^ cfg_i[0])) |=> !pend_o);

  // R9
  level_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_i[1] |=> (pend_o == $past(req_i ^ cfg_i[0])));

  // R13
  fall_no_set_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_i == 2'b10 && !pend_o && !req_i) |=> !pend_o);
endmodule

// File: rtl/irq_cfg_regfile.sv
module irq_cfg_regfile
  import irq_cfg_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      rd_en,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [DATA_W-1:0]         rd_data,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic [NUM_SRC-1:0]        irq_req,
  output logic [NUM_SRC-1:0]        src_en,
  output logic [NUM_SRC-1:0]        src_pend,
  output logic [NUM_SRC*PRIO_W-1:0] src_prio,
  output logic                      order_cfg
);
  localparam int IDX_W = $clog2(NUM_SRC);
  localparam int GWC_W = 2;

  reg_sel_e         wsel, rsel;
  logic [IDX_W-1:0] widx, ridx;

  logic [PRIO_W-1:0] prio_q [NUM_SRC];
  logic [GWC_W-1:0]  gwc_q  [NUM_SRC];
  logic [NUM_SRC-1:0] en_q;
  logic               glb_q;
  logic [NUM_SRC-1:0] clr_w;
  logic [NUM_SRC-1:0] pend_w;
  logic [DATA_W-1:0]  rd_val;
  logic               wdata_unused;

  assign wdata_unused = ^wr_data[DATA_W-1:PRIO_W];

  irq_cfg_decode #(.ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_wdec (
    .addr(wr_addr), .sel(wsel), .idx(widx)
  );
  irq_cfg_decode #(.ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_rdec (
    .addr(rd_addr), .sel(rsel), .idx(ridx)
  );

  // Configuration storage; index 0 is never decoded and keeps its reset value.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NUM_SRC; s++) begin
        prio_q[s] <= '0;
        gwc_q[s]  <= '0;
      end
      en_q  <= '0;
      glb_q <= 1'b0;
    end else if (wr_en) begin
      for (int s = 1; s < NUM_SRC; s++) begin
        if (widx == IDX_W'(s)) begin
          if (wsel == SEL_PRIO) prio_q[s] <= wr_data[PRIO_W-1:0];
          if (wsel == SEL_EN)   en_q[s]   <= wr_data[0];
          if (wsel == SEL_GWC)  gwc_q[s]  <= wr_data[GWC_W-1:0];
        end
      end
      if (wsel == SEL_GLB) glb_q <= wr_data[0];
    end
  end

  assign pend_w[0] = 1'b0;
  assign clr_w[0]  = 1'b0;

  for (genvar s = 1; s < NUM_SRC; s++) begin : g_src
    assign clr_w[s] = wr_en && (wsel == SEL_GWCLR) && (widx == IDX_W'(s));

    irq_gateway u_gw (
      .clk   (clk),
      .rst   (rst),
      .req_i (irq_req[s]),
      .cfg_i (gwc_q[s]),
      .clr_i (clr_w[s]),
      .pend_o(pend_w[s])
    );

    // R2
    prio_wr_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wsel == SEL_PRIO && widx == IDX_W'(s)) |=>
        (src_prio[s*PRIO_W +: PRIO_W] == $past(wr_data[PRIO_W-1:0])));
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_flat
    assign src_prio[s*PRIO_W +: PRIO_W] = prio_q[s];
  end

  assign src_en    = en_q;
  assign src_pend  = pend_w;
  assign order_cfg = glb_q;

  always_comb begin
    rd_val = '0;
    case (rsel)
      SEL_PRIO: rd_val[PRIO_W-1:0] = prio_q[ridx];
      SEL_PEND: rd_val[NUM_SRC-1:0] = pend_w;
      SEL_EN:   rd_val[0]           = en_q[ridx];
      SEL_GLB:  rd_val[0]           = glb_q;
      SEL_GWC:  rd_val[GWC_W-1:0]   = gwc_q[ridx];
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_val;
    else            rd_data <= '0;
  end

  // R11
  rd_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rd_data == '0));

  // R6
  pend_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rsel == SEL_PEND) |=> (rd_data[NUM_SRC-1:0] == $past(src_pend)));

  // R12
  slot0_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wsel == SEL_PRIO) |=> (!src_en[0] && !src_pend[0]));
endmodule

// File: tb/irq_cfg_regfile_tb.sv
module irq_cfg_regfile_tb;
  localparam int NS = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [15:0] rd_addr = '0, wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [31:0] irq_req = '0;
  logic [31:0] src_en, src_pend;
  logic [127:0] src_prio;
  logic        order_cfg;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [3:0] ep [NS];
  logic       ee [NS];
  logic [1:0] eg [NS];

  always #10 clk = ~clk;

  irq_cfg_regfile u_dut (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .irq_req(irq_req),
    .src_en(src_en), .src_pend(src_pend), .src_prio(src_prio), .order_cfg(order_cfg)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    rd_en = 1'b1; rd_addr = a;
    @(posedge clk); @(negedge clk);
    d = rd_data;
    rd_en = 1'b0;
  endtask

  task automatic set_all_gwc(input logic [1:0] v);
    for (int s = 1; s < NS; s++) begin
      wr(16'h4000 + 16'(4*s), 32'(v));
      eg[s] = v;
    end
  endtask

  task automatic clear_all();
    for (int s = 1; s < NS; s++) wr(16'h5000 + 16'(4*s), 32'hDEAD_BEEF);
  endtask

  task automatic verify_map(input string tag);
    logic [31:0] d;
    for (int s = 1; s < NS; s++) begin
      rd(16'(4*s), d);               check({tag, " R2 prio"}, d, 32'(ep[s]));
      rd(16'h2000 + 16'(4*s), d);    check({tag, " R3 en"}, d, 32'(ee[s]));
      rd(16'h4000 + 16'(4*s), d);    check({tag, " R4 gwc"}, d, 32'(eg[s]));
      check({tag, " R12 prio vec"}, 32'(src_prio[4*s +: 4]), 32'(ep[s]));
      check({tag, " R12 en vec"}, 32'(src_en[s]), 32'(ee[s]));
    end
    check({tag, " R12 slot0"}, {src_prio[3:0], 27'd0, src_en[0]}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, p, m, q;
    logic [15:0] bad [10];
    for (int s = 0; s < NS; s++) begin ep[s] = '0; ee[s] = 1'b0; eg[s] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    check("R1 en", src_en, 32'd0);
    check("R1 pend", src_pend, 32'd0);
    check("R1 prio", src_prio[31:0] | src_prio[127:96], 32'd0);
    check("R1 glb", 32'(order_cfg), 32'd0);
    check("R1 rdata", rd_data, 32'd0);
    verify_map("R1");

    // R2 R3 R4 sweep with garbage upper bits
    for (int s = 1; s < NS; s++) begin
      ep[s] = 4'((s*5 + 3) % 16);
      ee[s] = ((s / 2) % 2) == 1;
      eg[s] = 2'(s % 4);
      wr(16'(4*s), 32'hFFFF_FFF0 | 32'(ep[s]));
      wr(16'h2000 + 16'(4*s), 32'hFFFF_FFFE | 32'(ee[s]));
      wr(16'h4000 + 16'(4*s), 32'hFFFF_FFFC | 32'(eg[s]));
    end
    verify_map("sweep");

    // R5 global bit
    wr(16'h3000, 32'hFFFF_FFFF);
    rd(16'h3000, d); check("R5 read 1", d, 32'd1);
    check("R5 order_cfg 1", 32'(order_cfg), 32'd1);
    wr(16'h3000, 32'hFFFF_FFFE);
    rd(16'h3000, d); check("R5 read 0", d, 32'd0);
    check("R5 order_cfg 0", 32'(order_cfg), 32'd0);

    // R10 unmapped addresses
    bad[0] = 16'h0000; bad[1] = 16'h2000; bad[2] = 16'h4000; bad[3] = 16'h0080;
    bad[4] = 16'h2005; bad[5] = 16'h4006; bad[6] = 16'h3004; bad[7] = 16'h6004;
    bad[8] = 16'h0102; bad[9] = 16'hF000;
    for (int i = 0; i < 10; i++) wr(bad[i], 32'hFFFF_FFFF);
    for (int i = 0; i < 10; i++) begin
      rd(bad[i], d); check("R10 unmapped read", d, 32'd0);
    end
    check("R10 glb untouched", 32'(order_cfg), 32'd0);
    verify_map("R10 after");

    // R11 idle read returns zero
    rd(16'h0004, d);
    @(posedge clk); @(negedge clk);
    check("R11 idle zero", rd_data, 32'd0);

    // R6 pending read-only
    irq_req = '0;
    set_all_gwc(2'b10);
    clear_all();
    check("R6 pend cleared", src_pend, 32'd0);
    wr(16'h1000, 32'hFFFF_FFFF);
    check("R6 write ignored vec", src_pend, 32'd0);
    rd(16'h1000, d); check("R6 write ignored read", d, 32'd0);

    // R7 edge set and hold
    p = 32'hA5A5_5A5A;
    irq_req = p | 32'h1;
    @(posedge clk); @(negedge clk);
    check("R7 edge set", src_pend, p);
    irq_req = '0;
    repeat (2) @(posedge clk); @(negedge clk);
    check("R7 hold", src_pend, p);
    rd(16'h1000, d); check("R6 pend read", d, p);

    // R8 selective clear
    m = '0;
    for (int s = 1; s < NS; s++) if (s % 3 == 0) begin
      m[s] = 1'b1;
      wr(16'h5000 + 16'(4*s), 32'd0);
    end
    check("R8 partial clear", src_pend, p & ~m);
    clear_all();
    check("R8 all clear", src_pend, 32'd0);
    // R8 edge wins over clear in the same cycle
    irq_req[5] = 1'b1;
    wr(16'h5000 + 16'd20, 32'd0);
    check("R8 edge wins", src_pend, 32'h20);
    clear_all();
    check("R8 clear while high", src_pend, 32'd0);

    // R13 falling edge does not set in active-high edge mode
    irq_req = '0;
    @(posedge clk); @(negedge clk);
    check("R13 fall no set", src_pend, 32'd0);

    // R9 level modes
    set_all_gwc(2'b00);
    for (int k = 0; k < 4; k++) begin
      q = 32'h1357_9BDF * 32'(k + 1);
      irq_req = q;
      @(posedge clk); @(negedge clk);
      check("R9 level high", src_pend, q & ~32'h1);
    end
    q = 32'h0F0F_00F0;
    irq_req = q;
    clear_all();
    check("R9 clear ignored", src_pend, q);
    set_all_gwc(2'b01);
    for (int k = 0; k < 4; k++) begin
      q = 32'h2468_ACE1 ^ (32'h0101_0101 << k);
      irq_req = q;
      @(posedge clk); @(negedge clk);
      check("R9 level low", src_pend, ~q & ~32'h1);
    end

    // R13 inverted edge mode
    irq_req = '1;
    set_all_gwc(2'b11);
    clear_all();
    check("R13 inv idle", src_pend, 32'd0);
    q = 32'h8421_1248;
    irq_req = ~q;
    @(posedge clk); @(negedge clk);
    check("R13 inv fall sets", src_pend, q);
    irq_req = '1;
    repeat (2) @(posedge clk); @(negedge clk);
    check("R13 inv rise holds", src_pend, q);
    verify_map("final");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule